// File: doc/BRIEF.md
# Interlocked Handshake Memory Read Interface

This block joins a read requester and a small word memory over a shared set of lines: an address bus, a data bus, a read request line, a data ready line and a single acknowledge line that both parties drive (wired-OR). A read takes seven handshake steps. The requester presents an address and raises its request. The memory captures the address and acknowledges. The requester withdraws the address and the request, and the memory then releases the acknowledge. Only after that release may the memory put the word on the data bus and raise data ready. The requester latches the word and acknowledges on the same shared line. The memory then withdraws the data and data ready, and the requester drops its acknowledge.

Every handshake input is acted on only at a rising clock edge. The memory's data-preparation delay is a programmable cycle count. It starts when the address is captured and overlaps the address-phase handshake. A user raises `start` with an address and reads the returned word on `rd_data` when `done` pulses. The shared lines are brought out so that the protocol can be watched.

Top module: `rdhs_top`

## Requirements
- R1: While reset is held and right after it is released, read_req, data_rdy, ack, bus_oe, busy and done are 0, and bus_addr and bus_data are 0.
- R2: When start is seen at an idle clock edge, read_req is 1 after that edge with bus_addr equal to rd_addr, and ack stays 0 until the memory answers.
- R3: The memory raises ack one edge after it samples read_req high. The requester then clears read_req and bus_addr to 0 at the next edge.
- R4: The memory drops ack only after it has sampled read_req low. This happens one edge after read_req falls, so ack falls 3 edges after the start edge.
- R5: data_rdy rises only while ack has been sampled low, and never before the latency has run out. Counting edges from the edge where ack rose, data_rdy rises after exactly max(3, prep_lat+1) edges.
- R6: Memory word a holds ((a*37 + 11) XOR (a shifted left by 4)), truncated to the data width. While data_rdy is 1 this word for the captured address is on bus_data, and rd_data holds it after the read.
- R7: The requester raises ack one edge after it samples data_rdy. The memory drops data_rdy one edge later. The requester drops ack one edge after that and pulses done for one cycle. done therefore appears max(7, prep_lat+5) edges after the start edge.
- R8: Full interlock: read_req falls only after ack was sampled high, data_rdy falls only after ack was sampled high, and the requester's ack falls only after data_rdy was sampled low.
- R9: start is ignored while busy is 1. The address lines stay unchanged while read_req is held, and a start pulse during a read begins no second read.
- R10: bus_oe equals data_rdy, and bus_data is 0 whenever bus_oe is 0 (the data lines are released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; handshake inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a read (taken only while idle) |
| rd_addr | input | AW | Word address of the read |
| prep_lat | input | CW | Memory data-preparation delay in cycles |
| rd_data | output | DW | Word returned by the last read |
| busy | output | 1 | Requester is inside a transaction |
| done | output | 1 | One-cycle pulse at the end of a read |
| bus_addr | output | AW | Shared address lines (0 when not driven) |
| bus_data | output | DW | Shared data lines (0 when released) |
| bus_oe | output | 1 | Memory is driving the data lines |
| read_req | output | 1 | Read request line |
| data_rdy | output | 1 | Data ready line |
| ack | output | 1 | Shared acknowledge line (OR of both sides) |

## Verification
A wrong state in either controller shows at the ports as a handshake edge that appears at the wrong edge count. Typical cases are an acknowledge that overlaps data ready, a request that drops before it was acknowledged, or data driven while the address-phase acknowledge is still high. The interlock rules flag such faults on the very next edge. A wrong counter reload or a wrong gate on the preparation delay moves the data ready rise, and this is seen within one transaction against max(3, prep_lat+1). A wrong word or captured address shows on rd_data when done pulses. The sweep covers every address at several latencies on both sides of the point where the handshake, not the delay, sets the timing.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  typedef enum logic [1:0] {RQ_IDLE, RQ_ADDR, RQ_WAIT, RQ_ACK} rq_state_t;
  typedef enum logic [1:0] {MM_IDLE, MM_ACK, MM_PREP, MM_DRIVE} mm_state_t;

  // Content of memory word a (before truncation to the data width)
  function automatic logic [31:0] word_of(input int unsigned a);
    return (a * 32'd37 + 32'd11) ^ (a << 4);
  endfunction

  // Edges from the memory's acknowledge rise to its data-ready rise
  function automatic int unsigned ready_gap(input int unsigned lat);
    return (lat + 1 > 3) ? lat + 1 : 3;
  endfunction

endpackage

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          ack_in,
  input  logic          data_rdy_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_out,
  output logic          read_req,
  output logic          ack_out,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);

  rq_state_t state;

  assign busy = (state != RQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RQ_IDLE;
      addr_out <= '0;
      read_req <= 1'b0;
      ack_out  <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RQ_IDLE: if (start) begin
          addr_out <= start_addr;
          read_req <= 1'b1;
          state    <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_in) begin
          addr_out <= '0;
          read_req <= 1'b0;
          state    <= RQ_WAIT;
        end
        RQ_WAIT: if (data_rdy_in) begin
          rd_data <= data_in;
          ack_out <= 1'b1;
          state   <= RQ_ACK;
        end
        RQ_ACK: if (!data_rdy_in) begin
          ack_out <= 1'b0;
          done    <= 1'b1;
          state   <= RQ_IDLE;
        end
        default: state <= RQ_IDLE;
      endcase
    end
  end

  // R8
  req_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> $past(!data_rdy_in));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (read_req && $past(read_req)) |-> $stable(addr_out));

endmodule

// File: rtl/rdhs_memory.sv
module rdhs_memory
  import rdhs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          read_req,
  input  logic [AW-1:0] addr_in,
  input  logic          ack_in,
  input  logic [CW-1:0] prep_lat,
  output logic          ack_out,
  output logic          data_rdy,
  output logic          data_oe,
  output logic [DW-1:0] data_out
);

  localparam int DEPTH = 1 << AW;

  mm_state_t     state;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= DW'(word_of(i));
    end
  end

  assign data_oe  = (state == MM_DRIVE);
  assign data_out = data_oe ? mem[cap_addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= MM_IDLE;
      cap_addr <= '0;
      cnt      <= '0;
      ack_out  <= 1'b0;
      data_rdy <= 1'b0;
    end else begin
      unique case (state)
        MM_IDLE: if (read_req) begin
          cap_addr <= addr_in;
          cnt      <= prep_lat;
          ack_out  <= 1'b1;
          state    <= MM_ACK;
        end
        MM_ACK: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          if (!read_req) begin
            ack_out <= 1'b0;
            state   <= MM_PREP;
          end
        end
        MM_PREP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!ack_in) begin
            data_rdy <= 1'b1;
            state    <= MM_DRIVE;
          end
        end
        MM_DRIVE: if (ack_in) begin
          data_rdy <= 1'b0;
          state    <= MM_IDLE;
        end
        default: state <= MM_IDLE;
      endcase
    end
  end

  // R3
  mem_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(read_req));

  // R4
  mem_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> $past(!read_req));

  // R5
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> $past(!ack_in));

  // R8
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy) |-> $past(ack_in));

endmodule

// File: rtl/rdhs_top.sv
module rdhs_top
  import rdhs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  input  logic [CW-1:0] prep_lat,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe,
  output logic          read_req,
  output logic          data_rdy,
  output logic          ack
);

  logic req_ack_w;
  logic mem_ack_w;

  assign ack = req_ack_w | mem_ack_w;

  rdhs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(rd_addr),
    .ack_in(ack), .data_rdy_in(data_rdy), .data_in(bus_data),
    .addr_out(bus_addr), .read_req(read_req), .ack_out(req_ack_w),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  rdhs_memory #(.AW(AW), .DW(DW), .CW(CW)) u_mem (
    .clk(clk), .rst_n(rst_n), .read_req(read_req), .addr_in(bus_addr),
    .ack_in(ack), .prep_lat(prep_lat), .ack_out(mem_ack_w),
    .data_rdy(data_rdy), .data_oe(bus_oe), .data_out(bus_data)
  );

  // R8
  rreq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_req) |-> $past(ack));

  // R10
  oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == data_rdy);

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));

  // R8
  ack_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack_w && mem_ack_w));

endmodule

// File: tb/sim_rdhs_top.sv
module sim_rdhs_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] prep_lat = '0;
  logic [DW-1:0] rd_data, bus_data;
  logic [AW-1:0] bus_addr;
  logic          busy, done, bus_oe, read_req, data_rdy, ack;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rdhs_top #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .prep_lat(prep_lat), .rd_data(rd_data), .busy(busy), .done(done),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_oe(bus_oe),
    .read_req(read_req), .data_rdy(data_rdy), .ack(ack)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_word(input int a);
    return ((a * 37 + 11) ^ (a * 16)) % 65536;
  endfunction

  task automatic do_read(input int a, input int lat, input bit poke);
    int n = 0;
    int ack_edge = 0;
    int rdy_edge = 0;
    int done_edge = 0;
    int exp_rdy = (lat + 2 > 4) ? lat + 2 : 4;
    int exp_done = (lat + 5 > 7) ? lat + 5 : 7;
    @(negedge clk);
    start = 1'b1; rd_addr = AW'(a); prep_lat = CW'(lat);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 read_req", read_req, 1);
    chk("R2 bus_addr", bus_addr, a);
    chk("R2 ack", ack, 0);
    while (done_edge == 0 && n < 300) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 2) begin start = 1'b1; rd_addr = AW'(a ^ 1); end
      if (poke && n == 3) start = 1'b0;
      if (ack && ack_edge == 0) ack_edge = n;
      if (n == 2) begin
        chk("R3 read_req dropped", read_req, 0);
        chk("R3 bus_addr cleared", bus_addr, 0);
        chk("R4 ack held", ack, 1);
      end
      if (n == 3) chk("R4 ack released", ack, 0);
      if (data_rdy && rdy_edge == 0) begin
        rdy_edge = n;
        chk("R6 bus word", bus_data, expect_word(a));
        chk("R10 oe with rdy", bus_oe, 1);
      end
      if (rdy_edge == 0 && (bus_oe || bus_data != 0)) chk("R10 released", bus_data, 0);
      if (done) done_edge = n;
    end
    chk("R3 ack edge", ack_edge, 1);
    chk("R5 rdy gap", rdy_edge - ack_edge, exp_rdy - 1);
    chk("R7 done edge", done_edge, exp_done);
    chk("R6 rd_data", rd_data, expect_word(a));
    @(negedge clk);
    chk("R7 done pulse", done, 0);
    chk("R7 ack low", ack, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R9 no second read", read_req | busy, 0);
      chk("R9 rd_data kept", rd_data, expect_word(a));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lats[8] = '{0, 1, 2, 3, 4, 7, 12, 30};
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 read_req", read_req, 0);
    chk("R1 ack", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data_rdy", data_rdy, 0);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 bus_addr", bus_addr, 0);
    chk("R1 bus_data", bus_data, 0);
    for (int li = 0; li < 8; li++) begin
      for (int a = 0; a < 16; a++) do_read(a, lats[li], 1'b0);
    end
    // R9 start pulses while busy
    do_read(5, 0, 1'b1);
    do_read(10, 9, 1'b1);
    do_read(15, 63, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule